// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block tracks the interrupt state of a single processor across 256 vectors. It keeps three 256-bit state vectors: pending requests, vectors in service, and the trigger kind (edge or level) each pending vector was posted with. It also keeps a task priority register and a spurious/enable register. From the task priority and the most urgent in-service vector it derives a processor priority. It raises a level interrupt line whenever a pending vector outranks that processor priority.

A request source posts vectors together with their trigger kind. The core answers the interrupt line with an acknowledge pulse. One cycle later the block returns either the vector it has moved from pending to in-service, or a programmable spurious vector. When the handler finishes, it ends with an end-of-interrupt strobe, which retires the most urgent in-service vector. A larger vector number always means a higher priority, and the priority class is the upper nibble of the vector.

Top module: `vec_prio_ctrl`

## Requirements
- R1: Among pending vectors, a normal acknowledge always selects the highest-numbered one.
- R2: The processor priority is the task priority when the task priority class (bits 7:4) is at least the class of the highest in-service vector. Otherwise it is that in-service class followed by four zero bits. An empty in-service set counts as class 0.
- R3: `irq_o` is high exactly when all of these hold: enable bit 8 of the spurious register is set; at least one vector is pending; and either the processor priority is zero or the class of the highest pending vector is strictly greater than the processor priority class. It reflects the state one cycle after any posting, acknowledge, end-of-interrupt or register write.
- R4: Posting a vector sets its pending bit. It records the trigger kind: `req_level_i`=1 means level and 0 means edge. `ack_level_o` later returns the kind recorded last for the vector taken.
- R5: An acknowledge returns the low 8 bits of the spurious register, with `ack_level_o`=0, and changes no state in any of three cases: the block is disabled; nothing is pending; or the task priority is nonzero and the highest pending vector is less than or equal to it.
- R6: Any other acknowledge clears the highest pending bit and sets the same bit in service. In the cycle after `ack_req_i` it returns that vector with `ack_valid_o` high for exactly one cycle.
- R7: End-of-interrupt clears only the highest set in-service bit. It has no effect when the in-service set is empty.
- R8: After reset the task priority is 0, the spurious register is 0x0FF (disabled), and all three vectors are clear. Therefore `irq_o` is low and an acknowledge returns 0xFF.
- R9: The spurious register holds 9 bits. Bit 8 gates both the interrupt line and acknowledge, and bits 7:0 give the spurious vector.
- R10: All decisions made in one cycle (acknowledge, end-of-interrupt) use the state from before the clock edge. When a clear and a set hit the same bit in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Post a vector this cycle |
| req_vector_i | input | 8 | Vector being posted |
| req_level_i | input | 1 | Trigger kind of the posted vector: 1 level, 0 edge |
| ack_req_i | input | 1 | Core acknowledges the interrupt line |
| ack_valid_o | output | 1 | Acknowledge result valid (one cycle after request) |
| ack_vector_o | output | 8 | Vector taken, or spurious vector |
| ack_level_o | output | 1 | Trigger kind of the vector taken |
| eoi_i | input | 1 | End-of-interrupt strobe |
| tpr_we_i | input | 1 | Write task priority |
| tpr_wdata_i | input | 8 | Task priority write data |
| svr_we_i | input | 1 | Write spurious/enable register |
| svr_wdata_i | input | 9 | Spurious/enable write data (bit 8 enable) |
| irq_o | output | 1 | Level interrupt request to the core |

## Verification
State changes take effect at the clock edge that samples the stimulus. Because `irq_o` is combinational from registered state, it is due at the first falling edge after that rising edge. The acknowledge result comes from one register stage, so it is due at the same falling edge and gone one cycle later. The bench drives inputs on falling edges and advances a behavioural model at the rising edge. It then compares the interrupt line and the acknowledge outputs at the next falling edge. Directed sequences cover the fixed cases: class ties, task-priority blocking, end-of-interrupt on an empty set, and same-cycle conflicts.

// File: rtl/vpc_pkg.sv
package vpc_pkg;
  typedef enum logic [1:0] {
    ACK_IDLE = 2'd0,
    ACK_SPUR = 2'd1,
    ACK_TAKE = 2'd2
  } ack_kind_e;
endpackage

// File: rtl/vpc_fls.sv
// Find-last-set over N_WORDS x WORD_W bits; index 0 when empty.
module vpc_fls #(
  parameter int N_WORDS = 8,
  parameter int WORD_W  = 32,
  localparam int WIW    = $clog2(WORD_W),
  localparam int SW     = $clog2(N_WORDS),
  localparam int IW     = WIW + SW
) (
  input  logic [N_WORDS*WORD_W-1:0] bits_i,
  output logic                      any_o,
  output logic [IW-1:0]             idx_o
);
  logic [N_WORDS-1:0]           w_any;
  logic [N_WORDS-1:0][WIW-1:0]  w_idx;
  logic [SW-1:0]                sel;

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    logic [WORD_W-1:0] word;
    logic [WIW-1:0]    loc;
    assign word     = bits_i[w*WORD_W +: WORD_W];
    assign w_any[w] = |word;
    always_comb begin
      loc = '0;
      for (int b = 0; b < WORD_W; b++) begin
        if (word[b]) loc = WIW'(b);
      end
    end
    assign w_idx[w] = loc;
  end

  always_comb begin
    sel = '0;
    for (int w = 0; w < N_WORDS; w++) begin
      if (w_any[w]) sel = SW'(w);
    end
  end

  assign any_o = |w_any;
  assign idx_o = {sel, w_idx[sel]};
endmodule

// File: rtl/vpc_prio.sv
// Processor priority, interrupt decision, acknowledge blocking.
module vpc_prio #(
  parameter int VEC_W = 8,
  parameter int CLS_W = 4
) (
  input  logic [VEC_W-1:0] tpr_i,
  input  logic             en_i,
  input  logic             irr_any_i,
  input  logic [VEC_W-1:0] irr_hi_i,
  input  logic             isr_any_i,
  input  logic [VEC_W-1:0] isr_hi_i,
  output logic             irq_o,
  output logic             ack_block_o
);
  localparam int LOW_W = VEC_W - CLS_W;

  logic [CLS_W-1:0] tpr_cls, isr_cls, irr_cls, ppr_cls;
  logic [VEC_W-1:0] ppr;

  assign tpr_cls = tpr_i[VEC_W-1 -: CLS_W];
  assign irr_cls = irr_hi_i[VEC_W-1 -: CLS_W];
  assign isr_cls = isr_any_i ? isr_hi_i[VEC_W-1 -: CLS_W] : '0;
  assign ppr     = (tpr_cls >= isr_cls) ? tpr_i : {isr_cls, {LOW_W{1'b0}}};
  assign ppr_cls = ppr[VEC_W-1 -: CLS_W];

  assign irq_o = en_i && irr_any_i && ((ppr == '0) || (irr_cls > ppr_cls));

  // full-width compare against task priority, not class
  assign ack_block_o = !en_i || !irr_any_i ||
                       ((tpr_i != '0) && (irr_hi_i <= tpr_i));
endmodule

// File: rtl/vpc_vec_state.sv
// Pending / in-service / trigger vectors; clears applied before sets.
module vpc_vec_state #(
  parameter int NUM_VEC = 256,
  localparam int VEC_W  = $clog2(NUM_VEC)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               req_valid_i,
  input  logic [VEC_W-1:0]   req_vector_i,
  input  logic               req_level_i,
  input  logic               ack_take_i,
  input  logic [VEC_W-1:0]   ack_idx_i,
  input  logic               eoi_take_i,
  input  logic [VEC_W-1:0]   eoi_idx_i,
  output logic [NUM_VEC-1:0] irr_o,
  output logic [NUM_VEC-1:0] isr_o,
  output logic [NUM_VEC-1:0] tmr_o
);
  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
  logic [NUM_VEC-1:0] irr_d, isr_d, tmr_d;

  always_comb begin
    irr_d = irr_q;
    isr_d = isr_q;
    tmr_d = tmr_q;
    if (ack_take_i) irr_d[ack_idx_i] = 1'b0;
    if (eoi_take_i) isr_d[eoi_idx_i] = 1'b0;
    if (ack_take_i) isr_d[ack_idx_i] = 1'b1;
    if (req_valid_i) begin
      irr_d[req_vector_i] = 1'b1;
      tmr_d[req_vector_i] = req_level_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irr_q <= '0;
      isr_q <= '0;
      tmr_q <= '0;
    end else begin
      irr_q <= irr_d;
      isr_q <= isr_d;
      tmr_q <= tmr_d;
    end
  end

  assign irr_o = irr_q;
  assign isr_o = isr_q;
  assign tmr_o = tmr_q;
endmodule

// File: rtl/vec_prio_ctrl.sv
module vec_prio_ctrl
  import vpc_pkg::*;
#(
  parameter int N_WORDS  = 8,
  parameter int WORD_W   = 32,
  parameter int CLS_W    = 4,
  localparam int NUM_VEC = N_WORDS * WORD_W,
  localparam int VEC_W   = $clog2(NUM_VEC)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_valid_i,
  input  logic [VEC_W-1:0] req_vector_i,
  input  logic             req_level_i,
  input  logic             ack_req_i,
  output logic             ack_valid_o,
  output logic [VEC_W-1:0] ack_vector_o,
  output logic             ack_level_o,
  input  logic             eoi_i,
  input  logic             tpr_we_i,
  input  logic [VEC_W-1:0] tpr_wdata_i,
  input  logic             svr_we_i,
  input  logic [VEC_W:0]   svr_wdata_i,
  output logic             irq_o
);
  localparam logic [VEC_W:0] SVR_RST = {1'b0, {VEC_W{1'b1}}};

  logic [NUM_VEC-1:0] irr_q, isr_q, tmr_q;
  logic               irr_any, isr_any, ack_block;
  logic [VEC_W-1:0]   irr_hi, isr_hi;
  logic [VEC_W-1:0]   tpr_q;
  logic [VEC_W:0]     svr_q;
  ack_kind_e          ack_kind;
  logic               ack_valid_q, ack_level_q;
  logic [VEC_W-1:0]   ack_vector_q;

  vpc_fls #(.N_WORDS(N_WORDS), .WORD_W(WORD_W)) u_irr_fls (
    .bits_i(irr_q), .any_o(irr_any), .idx_o(irr_hi)
  );

  vpc_fls #(.N_WORDS(N_WORDS), .WORD_W(WORD_W)) u_isr_fls (
    .bits_i(isr_q), .any_o(isr_any), .idx_o(isr_hi)
  );

  vpc_prio #(.VEC_W(VEC_W), .CLS_W(CLS_W)) u_prio (
    .tpr_i       (tpr_q),
    .en_i        (svr_q[VEC_W]),
    .irr_any_i   (irr_any),
    .irr_hi_i    (irr_hi),
    .isr_any_i   (isr_any),
    .isr_hi_i    (isr_hi),
    .irq_o       (irq_o),
    .ack_block_o (ack_block)
  );

  always_comb begin
    if (!ack_req_i)     ack_kind = ACK_IDLE;
    else if (ack_block) ack_kind = ACK_SPUR;
    else                ack_kind = ACK_TAKE;
  end

  vpc_vec_state #(.NUM_VEC(NUM_VEC)) u_state (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .req_vector_i (req_vector_i),
    .req_level_i  (req_level_i),
    .ack_take_i   (ack_kind == ACK_TAKE),
    .ack_idx_i    (irr_hi),
    .eoi_take_i   (eoi_i && isr_any),
    .eoi_idx_i    (isr_hi),
    .irr_o        (irr_q),
    .isr_o        (isr_q),
    .tmr_o        (tmr_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tpr_q <= '0;
      svr_q <= SVR_RST;
    end else begin
      if (tpr_we_i) tpr_q <= tpr_wdata_i;
      if (svr_we_i) svr_q <= svr_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_valid_q  <= 1'b0;
      ack_vector_q <= '0;
      ack_level_q  <= 1'b0;
    end else begin
      ack_valid_q <= (ack_kind != ACK_IDLE);
      unique case (ack_kind)
        ACK_TAKE: begin
          ack_vector_q <= irr_hi;
          ack_level_q  <= tmr_q[irr_hi];
        end
        ACK_SPUR: begin
          ack_vector_q <= svr_q[VEC_W-1:0];
          ack_level_q  <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  assign ack_valid_o  = ack_valid_q;
  assign ack_vector_o = ack_vector_q;
  assign ack_level_o  = ack_level_q;
endmodule

// File: rtl/vec_prio_ctrl_chk.sv
module vec_prio_ctrl_chk #(
  parameter int NUM_VEC = 256,
  parameter int VEC_W   = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_valid_i,
  input logic [VEC_W-1:0]   req_vector_i,
  input logic               ack_req_i,
  input logic               ack_valid_o,
  input logic               eoi_i,
  input logic               irq_o,
  input logic               en_i,
  input logic [NUM_VEC-1:0] irr_i,
  input logic [NUM_VEC-1:0] isr_i
);
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (en_i && (irr_i != '0))); // R3

  AST_POST_SETS_PENDING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> irr_i[$past(req_vector_i)]); // R4

  AST_ACK_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_req_i |=> ack_valid_o); // R6

  AST_ACK_NO_STRAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_req_i |=> !ack_valid_o); // R6

  AST_EOI_RETIRES_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !ack_req_i && (isr_i != '0)) |=>
      ($countones(isr_i) == $past($countones(isr_i)) - 1)); // R7

  AST_EOI_EMPTY_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi_i && !ack_req_i && (isr_i == '0)) |=> (isr_i == '0)); // R7
endmodule

bind vec_prio_ctrl vec_prio_ctrl_chk #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_vector_i (req_vector_i),
  .ack_req_i    (ack_req_i),
  .ack_valid_o  (ack_valid_o),
  .eoi_i        (eoi_i),
  .irq_o        (irq_o),
  .en_i         (svr_q[VEC_W]),
  .irr_i        (irr_q),
  .isr_i        (isr_q)
);

// File: tb/vec_prio_ctrl_bench.sv
module vec_prio_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 0, req_level = 0, ack_req = 0, eoi = 0;
  logic       tpr_we = 0, svr_we = 0;
  logic [7:0] req_vector = 0, tpr_wdata = 0;
  logic [8:0] svr_wdata = 0;
  logic       ack_valid, ack_level, irq;
  logic [7:0] ack_vector;

  int errors = 0, checks = 0;
  bit done = 0;

  bit [255:0] m_irr, m_isr, m_tmr;
  bit [7:0]   m_tpr;
  bit [8:0]   m_svr;

  always #10 clk = ~clk;

  vec_prio_ctrl u_vec_prio_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_vector_i(req_vector), .req_level_i(req_level),
    .ack_req_i(ack_req), .ack_valid_o(ack_valid), .ack_vector_o(ack_vector),
    .ack_level_o(ack_level), .eoi_i(eoi),
    .tpr_we_i(tpr_we), .tpr_wdata_i(tpr_wdata),
    .svr_we_i(svr_we), .svr_wdata_i(svr_wdata), .irq_o(irq)
  );

  function automatic int hi(bit [255:0] v);
    for (int i = 255; i >= 0; i--) if (v[i]) return i;
    return -1;
  endfunction

  function automatic bit model_irq();
    int ih = hi(m_irr);
    int sh = hi(m_isr);
    int sc = (sh < 0) ? 0 : (sh >> 4);
    int tc = int'(m_tpr) >> 4;
    int ppr = (tc >= sc) ? int'(m_tpr) : (sc << 4);
    return m_svr[8] && (ih >= 0) && ((ppr == 0) || ((ih >> 4) > (ppr >> 4)));
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // one clock: model advances at the rising edge, compare at the falling edge
  task automatic cyc();
    int ih, sh;
    bit exp_av, exp_lvl, blocked;
    bit [7:0] exp_vec;
    bit [255:0] n_irr, n_isr, n_tmr;
    @(posedge clk);
    ih = hi(m_irr);
    sh = hi(m_isr);
    exp_av = ack_req; exp_vec = 0; exp_lvl = 0; blocked = 1;
    if (ack_req) begin
      blocked = !m_svr[8] || (ih < 0) || ((m_tpr != 0) && (ih <= int'(m_tpr)));
      if (blocked) exp_vec = m_svr[7:0];
      else begin exp_vec = 8'(ih); exp_lvl = m_tmr[ih]; end
    end
    n_irr = m_irr; n_isr = m_isr; n_tmr = m_tmr;
    if (ack_req && !blocked) n_irr[ih] = 0;
    if (eoi && sh >= 0) n_isr[sh] = 0;
    if (ack_req && !blocked) n_isr[ih] = 1;
    if (req_valid) begin n_irr[req_vector] = 1; n_tmr[req_vector] = req_level; end
    m_irr = n_irr; m_isr = n_isr; m_tmr = n_tmr;
    if (tpr_we) m_tpr = tpr_wdata;
    if (svr_we) m_svr = svr_wdata;
    @(negedge clk);
    chk(irq == model_irq(), "R3 irq line", irq, model_irq());
    chk(ack_valid == exp_av, "R6 ack valid", ack_valid, exp_av);
    if (exp_av) begin
      chk(ack_vector == exp_vec, "R1/R5/R6 ack vector", ack_vector, exp_vec);
      chk(ack_level == exp_lvl, "R4 ack trigger", ack_level, exp_lvl);
    end
    req_valid = 0; ack_req = 0; eoi = 0; tpr_we = 0; svr_we = 0;
  endtask

  task automatic post(input bit [7:0] v, input bit lvl);
    req_valid = 1; req_vector = v; req_level = lvl; cyc();
  endtask

  task automatic do_eoi();
    eoi = 1; cyc();
  endtask

  task automatic set_tpr(input bit [7:0] v);
    tpr_we = 1; tpr_wdata = v; cyc();
  endtask

  task automatic set_svr(input bit [8:0] v);
    svr_we = 1; svr_wdata = v; cyc();
  endtask

  task automatic ack_chk(input bit [7:0] ev, input bit el, input string tag);
    ack_req = 1; cyc();
    chk(ack_valid && ack_vector == ev && ack_level == el, tag,
        {ack_valid, ack_level, ack_vector}, {2'b10 | el, ev});
  endtask

  task automatic irq_chk(input bit e, input string tag);
    chk(irq == e, tag, irq, e);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_irr = 0; m_isr = 0; m_tmr = 0; m_tpr = 0; m_svr = 9'h0FF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8 reset state
    irq_chk(0, "R8 irq low after reset");
    ack_chk(8'hFF, 0, "R8 spurious 0xFF after reset");
    post(8'h20, 0);
    irq_chk(0, "R9 disabled at reset");
    ack_chk(8'hFF, 0, "R5 disabled ack");
    // R9 enable with spurious 0x3F
    set_svr(9'h13F);
    irq_chk(1, "R9 enable bit");
    ack_chk(8'h20, 0, "R6 take 0x20");
    do_eoi();
    ack_chk(8'h3F, 0, "R5 empty pending");
    // R1 ordering, R4 level
    post(8'h45, 0);
    post(8'h90, 1);
    irq_chk(1, "R3 pending above zero ppr");
    ack_chk(8'h90, 1, "R1 highest wins");
    irq_chk(0, "R2 in-service class 9 masks 0x45");
    post(8'h9F, 0);
    irq_chk(0, "R3 equal class blocked");
    post(8'hA0, 0);
    irq_chk(1, "R3 higher class");
    ack_chk(8'hA0, 0, "R6 take 0xA0");
    do_eoi();
    irq_chk(0, "R7 0x90 still in service");
    do_eoi();
    irq_chk(1, "R7 in-service empty");
    // R5 task priority blocking
    set_tpr(8'h9F);
    irq_chk(0, "R2 tpr class 9");
    ack_chk(8'h3F, 0, "R5 blocked by tpr");
    set_tpr(8'h80);
    irq_chk(1, "R2 tpr class 8");
    ack_chk(8'h9F, 0, "R5 state kept after spurious");
    do_eoi();
    do_eoi();
    irq_chk(0, "R7 extra eoi harmless, tpr 0x80");
    set_tpr(8'h00);
    irq_chk(1, "R2 tpr zero");
    ack_chk(8'h45, 0, "R1 last pending");
    do_eoi();
    // R4 last trigger kind wins
    post(8'h30, 1);
    post(8'h30, 0);
    ack_chk(8'h30, 0, "R4 last trigger recorded");
    do_eoi();
    // R10 same-cycle ordering
    post(8'h50, 0);
    ack_req = 1; req_valid = 1; req_vector = 8'h50; req_level = 1; cyc();
    chk(ack_vector == 8'h50 && ack_level == 0, "R10 ack uses pre-edge trigger",
        {ack_level, ack_vector}, 9'h050);
    ack_chk(8'h50, 1, "R10 post wins over ack clear");
    post(8'h60, 0);
    eoi = 1; ack_req = 1; cyc();
    post(8'h55, 0);
    irq_chk(0, "R10 0x60 in service after eoi+ack");
    do_eoi();
    irq_chk(1, "R10 in-service empty");
    ack_chk(8'h55, 0, "R6 take 0x55");
    do_eoi();
    // disable with pending
    post(8'h77, 1);
    set_svr(9'h0FF);
    irq_chk(0, "R3 disabled");
    ack_chk(8'hFF, 0, "R5 disabled ack");
    set_svr(9'h1FF);
    irq_chk(1, "R9 re-enabled");
    ack_chk(8'h77, 1, "R6 take 0x77");
    do_eoi();
    // random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 99);
      req_valid = (r < 40);
      req_vector = 8'($urandom_range(0, 255));
      req_level = 1'($urandom_range(0, 1));
      ack_req = ($urandom_range(0, 99) < 30);
      eoi = ($urandom_range(0, 99) < 25);
      tpr_we = ($urandom_range(0, 99) < 4);
      tpr_wdata = ($urandom_range(0, 1) == 1) ? 8'h00 : 8'($urandom_range(0, 255));
      svr_we = ($urandom_range(0, 99) < 2);
      svr_wdata = {($urandom_range(0, 9) != 0), 8'($urandom_range(0, 255))};
      cyc();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule